// File: doc/BRIEF.md
# Completion Ring Fill-Level Interrupt Monitor

This block follows how full a circular completion ring in host memory is. Hardware posts a completion by pulsing `post_i`, and the producer index moves forward one slot. Software moves the consumer index through a small register write port. From the two indices the block computes the pending count and the free count. It compares the selected count against a programmable threshold and sets a sticky interrupt status bit when the threshold is met.

A control word sets several things: the ring's base address (256-byte aligned), the ring size (4 KB or 8 KB), the entry size (one, two or four 32-bit words), the threshold and the comparison mode. The block also outputs the byte address of the next entry that will be written, so that a DMA engine can use it directly. Software may also load the producer index, but only after it has turned on a separate enable bit.

Top module: `cq_thresh_mon`

## Requirements
- R1: After reset the producer index, consumer index, control word and enable bit are all zero. `prod_idx_o`, `entry_addr_o` and `irq_o` read 0.
- R2: The control word (register select 0) has these fields: base address bits [31:8] in bits [31:8], mode in bit 7, size in bit 6, entry type in bits [5:4] and threshold in bits [3:0]. The ring is 4096 bytes when size is 0 and 8192 bytes when size is 1. An entry is 4 bytes for type 00, 8 bytes for types 01 and 10, and 16 bytes for type 11. The entry count is the ring bytes divided by the entry bytes.
- R3: Each cycle with `post_i` high and the ring not full, the producer index increases by one. It wraps to 0 at the entry count.
- R4: The ring is full when the pending count equals the entry count minus one. A post pulse while the ring is full leaves the producer index unchanged.
- R5: A producer write (register select 2) loads the index only while the enable bit (register select 3, bit 0) is 1. While the enable bit is 0, the write has no effect.
- R6: The pending count is (producer − consumer) modulo the entry count. The free count is the entry count − 1 − pending. In mode 0, `irq_o` is set one cycle after the free count becomes ≤ 4 × threshold.
- R7: In mode 1, `irq_o` is set one cycle after the pending count becomes ≥ 4 × threshold.
- R8: `irq_o` stays set until a cycle with `irq_clr_i` high clears it. If the condition still holds, it sets again on the following cycle.
- R9: `entry_addr_o` equals {base, 8'h00} + producer index × entry bytes.
- R10: When a producer write and a post pulse arrive in the same cycle, the written value wins.
- R11: A consumer write (register select 1) loads the consumer index, masked to the ring's index range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 consumer, 2 producer, 3 enable |
| reg_wdata_i | input | 32 | Register write data |
| post_i | input | 1 | One completion posted by hardware |
| irq_clr_i | input | 1 | Clears the interrupt status bit |
| prod_idx_o | output | 11 | Current producer index |
| entry_addr_o | output | 32 | Byte address of the next entry to write |
| irq_o | output | 1 | Sticky interrupt status bit |

## Verification
The bench drives the ring right up to full and posts once more. A design with no full guard would then wrap the producer index onto the consumer. It sets the free count exactly one slot above the threshold and then exactly on it, which catches an off-by-one or a strict comparison in either mode. It clears the status bit while the condition still holds, and also once the condition has gone away. A bit that is not sticky, or one that sets again in the same cycle, shows up there. Producer writes are tried with the enable bit off and on, and also at the same time as a post. The bench then wraps an 8 KB ring of 2048 entries, so a mask taken from the wrong size field fails.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef struct packed {
    logic [ADDR_W-9:0] base;
    logic              mode;
    logic              size;
    logic [1:0]        etype;
    logic [3:0]        thr;
  } cq_ctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CONS = 2'd1;
  localparam logic [1:0] SEL_PROD = 2'd2;
  localparam logic [1:0] SEL_OPT  = 2'd3;
endpackage

// File: rtl/cq_ring_geom.sv
module cq_ring_geom
  import cq_pkg::*;
#(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned RING_LOG2 = 12,
  parameter int unsigned WORD_LOG2 = 2
) (
  input  cq_ctrl_t         ctrl_i,
  output logic [IDX_W-1:0] mask_o,
  output logic [2:0]       ent_shift_o
);
  localparam int unsigned MAX_LOG2 = RING_LOG2 + 1 - WORD_LOG2;

  logic [1:0] words_log2;
  logic [4:0] ent_log2;

  always_comb begin
    unique case (ctrl_i.etype)
      2'b00:   words_log2 = 2'd0;
      2'b11:   words_log2 = 2'd2;
      default: words_log2 = 2'd1;
    endcase
    ent_shift_o = 3'(WORD_LOG2) + 3'(words_log2);
    ent_log2    = 5'(RING_LOG2) + 5'(ctrl_i.size) - 5'(ent_shift_o);
    mask_o      = IDX_W'((32'd1 << ent_log2) - 32'd1);
  end

  initial begin
    assert (IDX_W >= MAX_LOG2) else $error("IDX_W too narrow for largest ring");
  end
endmodule

// File: rtl/cq_index_ctrl.sv
module cq_index_ctrl #(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] mask_i,
  input  logic             post_i,
  input  logic             prod_we_i,
  input  logic [IDX_W-1:0] prod_wdata_i,
  input  logic             cons_we_i,
  input  logic [IDX_W-1:0] cons_wdata_i,
  output logic [IDX_W-1:0] prod_o,
  output logic [IDX_W-1:0] valid_o,
  output logic [IDX_W-1:0] empty_o,
  output logic             full_o
);
  logic [IDX_W-1:0] prod_q, cons_q;

  always_comb begin
    valid_o = (prod_q - cons_q) & mask_i;
    empty_o = mask_i - valid_o;
    full_o  = (valid_o == mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (prod_we_i)                prod_q <= prod_wdata_i & mask_i;
      else if (post_i && !full_o)   prod_q <= (prod_q + 1'b1) & mask_i;
      if (cons_we_i)                cons_q <= cons_wdata_i & mask_i;
    end
  end

  assign prod_o = prod_q;

  p_post_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i && !full_o && !prod_we_i |=> prod_o == (($past(prod_o) + 1'b1) & $past(mask_i)));
  p_full_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i && full_o && !prod_we_i |=> $stable(prod_o));
  p_sw_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_we_i |=> prod_o == ($past(prod_wdata_i) & $past(mask_i)));
endmodule

// File: rtl/cq_thresh_eval.sv
module cq_thresh_eval #(
  parameter int unsigned IDX_W = 11,
  parameter int unsigned THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [IDX_W-1:0] valid_i,
  input  logic [IDX_W-1:0] empty_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [IDX_W-1:0] limit;
  logic             hit;
  logic             irq_q;

  always_comb begin
    limit = IDX_W'(thr_i) << 2;
    hit   = mode_i ? (valid_i >= limit) : (empty_i <= limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  p_free_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && (empty_i <= (IDX_W'(thr_i) << 2)) && !clr_i |=> irq_o);
  p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && (valid_i >= (IDX_W'(thr_i) << 2)) && !clr_i |=> irq_o);
endmodule

// File: rtl/cq_thresh_mon.sv
module cq_thresh_mon
  import cq_pkg::*;
#(
  parameter int unsigned IDX_W = 11,
  parameter int unsigned THR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              post_i,
  input  logic              irq_clr_i,
  output logic [IDX_W-1:0]  prod_idx_o,
  output logic [ADDR_W-1:0] entry_addr_o,
  output logic              irq_o
);
  cq_ctrl_t         ctrl_q;
  logic             pwe_q;
  logic [IDX_W-1:0] mask;
  logic [2:0]       ent_shift;
  logic [IDX_W-1:0] valid, empty;
  logic             full;
  logic             prod_we, cons_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pwe_q  <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_sel_i == SEL_CTRL) ctrl_q <= cq_ctrl_t'(reg_wdata_i);
      if (reg_sel_i == SEL_OPT)  pwe_q  <= reg_wdata_i[0];
    end
  end

  assign cons_we = reg_we_i && (reg_sel_i == SEL_CONS);
  assign prod_we = reg_we_i && (reg_sel_i == SEL_PROD) && pwe_q;

  cq_ring_geom #(.IDX_W(IDX_W)) u_geom (
    .ctrl_i      (ctrl_q),
    .mask_o      (mask),
    .ent_shift_o (ent_shift)
  );

  cq_index_ctrl #(.IDX_W(IDX_W)) u_idx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_i       (mask),
    .post_i       (post_i),
    .prod_we_i    (prod_we),
    .prod_wdata_i (reg_wdata_i[IDX_W-1:0]),
    .cons_we_i    (cons_we),
    .cons_wdata_i (reg_wdata_i[IDX_W-1:0]),
    .prod_o       (prod_idx_o),
    .valid_o      (valid),
    .empty_o      (empty),
    .full_o       (full)
  );

  cq_thresh_eval #(.IDX_W(IDX_W), .THR_W(THR_W)) u_eval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (ctrl_q.mode),
    .thr_i   (ctrl_q.thr[THR_W-1:0]),
    .valid_i (valid),
    .empty_i (empty),
    .clr_i   (irq_clr_i),
    .irq_o   (irq_o)
  );

  assign entry_addr_o = {ctrl_q.base, 8'h00} + (ADDR_W'(prod_idx_o) << ent_shift);

  p_sw_prod_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_sel_i == SEL_PROD) && !pwe_q && !post_i |=> $stable(prod_idx_o));
  p_base_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_idx_o == '0 |-> entry_addr_o[7:0] == 8'h00);
endmodule

// File: tb/cq_thresh_mon_bench.sv
module cq_thresh_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        post_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic [IDX_W-1:0] prod_idx_o;
  logic [31:0] entry_addr_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t it;
  event chk_ev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cq_thresh_mon u_cq_thresh_mon (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .post_i, .irq_clr_i, .prod_idx_o, .entry_addr_o, .irq_o
  );

  // monitor: pops expectations and compares against the outputs
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.sel)
        0:       act = 32'(prod_idx_o);
        1:       act = entry_addr_o;
        default: act = 32'(irq_o);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s act=%0h exp=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [31:0] v, input string tag);
    exp_q.push_back('{sel, v, tag});
    -> chk_ev;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    cyc(1);
    reg_we_i = 1'b0;
  endtask

  task automatic posts(input int n);
    for (int i = 0; i < n; i++) begin
      post_i = 1'b1;
      cyc(1);
    end
    post_i = 1'b0;
  endtask

  task automatic clr_pulse();
    irq_clr_i = 1'b1;
    cyc(1);
    irq_clr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    expect_val(0, 0, "R1 prod reset");
    expect_val(1, 0, "R1 addr reset");
    expect_val(2, 0, "R1 irq reset");

    wr(2'd0, 32'h0001_2300);           // 4 KB, 4 B entries, mode0 thr0
    expect_val(1, 32'h12300, "R9 base addr");
    posts(5);
    expect_val(0, 5, "R3 post advance");
    expect_val(1, 32'h12314, "R9 addr 4B entries");
    expect_val(2, 0, "R6 no irq with free ring");

    wr(2'd0, 32'h0001_2330);           // 16 B entries, 256 slots
    expect_val(1, 32'h12350, "R2 16B entry addr");
    wr(2'd0, 32'h0001_2320);           // 8 B entries
    expect_val(1, 32'h12328, "R2 8B entry addr");
    wr(2'd0, 32'h0001_2330);

    posts(250);                        // prod 255, ring full
    cyc(1);
    expect_val(0, 255, "R2 256-slot fill");
    expect_val(2, 1, "R6 full ring thr0 sets irq");
    posts(1);
    expect_val(0, 255, "R4 post ignored when full");

    clr_pulse();
    expect_val(2, 0, "R8 clear strobe");
    cyc(1);
    expect_val(2, 1, "R8 re-set while condition holds");

    wr(2'd1, 32'd255);                 // drain: pending 0
    clr_pulse();
    cyc(1);
    expect_val(2, 0, "R8 stays clear after drain");

    wr(2'd0, 32'h0001_233F);           // mode0 thr 15 -> 60 free
    posts(194);                        // pending 194, free 61
    expect_val(0, 193, "R3 wrap at 256");
    cyc(1);
    expect_val(2, 0, "R6 free 61 above limit");
    posts(1);                          // free 60
    cyc(1);
    expect_val(2, 1, "R6 free equals limit");

    wr(2'd1, 32'd194);                 // R11 consumer load: pending 0
    wr(2'd0, 32'h0001_23C2);           // mode1, 8 KB, 4 B, thr 2 -> 8
    clr_pulse();
    cyc(1);
    expect_val(2, 0, "R11 R7 pending 0 below limit");
    posts(7);
    cyc(1);
    expect_val(2, 0, "R7 pending 7 below limit");
    posts(1);
    cyc(1);
    expect_val(2, 1, "R7 pending equals limit");
    expect_val(0, 202, "R3 prod after posts");
    expect_val(1, 32'h12628, "R9 addr 8 KB ring");

    wr(2'd2, 32'd100);
    expect_val(0, 202, "R5 producer write ignored");
    wr(2'd3, 32'd1);
    wr(2'd2, 32'd100);
    expect_val(0, 100, "R5 producer write enabled");
    expect_val(1, 32'h12490, "R9 addr after sw write");

    reg_we_i = 1'b1; reg_sel_i = 2'd2; reg_wdata_i = 32'd300; post_i = 1'b1;
    cyc(1);
    reg_we_i = 1'b0; post_i = 1'b0;
    expect_val(0, 300, "R10 write beats post");

    wr(2'd1, 32'd5);
    wr(2'd2, 32'd2047);
    posts(1);
    expect_val(0, 0, "R3 wrap at 2048");
    expect_val(1, 32'h12300, "R9 addr after wrap");

    cyc(1);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule